// File: doc/BRIEF.md
# Modem Dataset Status Controller

This block holds the modem-control half of one terminal line's receive status word. Software sets four control bits: data terminal ready, request to send, secondary transmit and the dataset interrupt enable. The block keeps four read-only indications: ring, carrier detect, clear to send and a sticky dataset-change flag. These indications move in response to the line connecting, the line dropping, and software raising or lowering data terminal ready. A lowering of data terminal ready on a live line also sends a one-cycle hangup pulse toward the line.

Within one clock cycle, events take effect in a fixed order. A status read clears dataset change first. Line events come next, and the register write comes last. Because of this, a read that coincides with a new event leaves the flag set for that new event. A dataset interrupt request is raised while dataset change and its enable are both set. A mode input turns all modem behaviour off. While it is low, every bit reads 0 and the stored state is wiped. A synchronous per-line reset keeps data terminal ready and clears the rest.

Top module: `mdm_status_ctrl`

## Requirements
- R1: Writes load the control bits DTR (bit 1), RTS (bit 2), secondary transmit (bit 3) and dataset-interrupt enable (bit 5), and these read back from `status_o`. Write data in bits 15, 14, 13 and 12 has no effect on the stored status.
- R2: A connect pulse while DTR is 1 sets carrier detect (bit 12), clear to send (bit 13) and dataset change (bit 15).
- R3: A connect pulse while DTR is 0 sets ring (bit 14) and dataset change (bit 15).
- R4: A write that takes DTR from 0 to 1 on a connected line clears ring and sets carrier, clear to send and dataset change. On a disconnected line the same write changes only the control bits.
- R5: A write that takes DTR from 1 to 0 on a connected line gives a `hangup_o` pulse exactly one cycle wide, in the cycle after the write. It sets dataset change only if carrier was set, and it always clears carrier, ring and clear to send. A DTR fall on a disconnected line gives no hangup.
- R6: While `line_up_i` is low, carrier, ring and clear to send are cleared. If carrier was set, dataset change is set. If carrier was clear, dataset change is left as it was.
- R7: `rd_en_i` clears dataset change and withdraws the interrupt request. A set event in the same cycle as the read leaves the flag set.
- R8: `ds_irq_o` is high while dataset change and its enable are both set. Writing the enable while the flag is already set raises the request in the next cycle.
- R9: `line_rst_i` in modem mode keeps DTR and clears every other status bit.
- R10: With `modem_en_i` low, `status_o`, `ds_irq_o` and `hangup_o` read 0 at once, and writes and line events have no effect. The stored state is cleared, so DTR reads 0 after modem mode is turned back on.
- R11: Asserting `rst_ni` clears all status bits and both outputs.
- R12: Status bit 10 shows `sec_rx_i` as sampled at the previous clock edge.
- R13: A connect pulse while `line_up_i` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| modem_en_i | input | 1 | Modem behaviour enable |
| line_rst_i | input | 1 | Synchronous line reset (keeps DTR) |
| line_up_i | input | 1 | Line connected level |
| conn_pulse_i | input | 1 | New connection event |
| sec_rx_i | input | 1 | Secondary receive level |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | 16 | Status register write data |
| rd_en_i | input | 1 | Status register read strobe |
| status_o | output | 16 | Status register contents |
| ds_irq_o | output | 1 | Dataset interrupt request |
| hangup_o | output | 1 | Hangup pulse toward the line |

## Verification
The bench drives collisions between events. It reads in the same cycle as a connect pulse or a DTR rise, where a design that let the read clear last would lose a dataset change. It lowers DTR both with and without carrier and both on and off a live line. A design that flagged dataset change every time, or hung up an idle line, fails there. It also pulses connect while the line is down, enables the interrupt while the flag is already set, and checks the DTR-preserving line reset against the full wipe of mode-off. Those checks catch a request that waits for a fresh event and a reset that loses or keeps the wrong bits.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int REG_W    = 16;
  localparam int POS_DSC  = 15;
  localparam int POS_RING = 14;
  localparam int POS_CTS  = 13;
  localparam int POS_CD   = 12;
  localparam int POS_SRX  = 10;
  localparam int POS_DSIE = 5;
  localparam int POS_SECX = 3;
  localparam int POS_RTS  = 2;
  localparam int POS_DTR  = 1;

  typedef struct packed {
    logic dsc;
    logic ring;
    logic cts;
    logic cd;
    logic sec_rx;
    logic dsie;
    logic secx;
    logic rts;
    logic dtr;
  } mdm_state_t;

  typedef struct packed {
    logic dsie;
    logic secx;
    logic rts;
    logic dtr;
  } mdm_ctrl_t;

  function automatic mdm_ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
    mdm_ctrl_t c;
    c.dsie = w[POS_DSIE];
    c.secx = w[POS_SECX];
    c.rts  = w[POS_RTS];
    c.dtr  = w[POS_DTR];
    return c;
  endfunction
endpackage

// File: rtl/mdm_link_stage.sv
// Connect / disconnect effects on the read-only indications.
module mdm_link_stage
  import mdm_pkg::*;
(
  input  mdm_state_t cur_i,
  input  logic       line_up_i,
  input  logic       conn_pulse_i,
  output mdm_state_t nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (!line_up_i) begin
      if (cur_i.cd) nxt_o.dsc = 1'b1;
      nxt_o.cd   = 1'b0;
      nxt_o.ring = 1'b0;
      nxt_o.cts  = 1'b0;
    end else if (conn_pulse_i) begin
      nxt_o.dsc = 1'b1;
      if (cur_i.dtr) begin
        nxt_o.cd  = 1'b1;
        nxt_o.cts = 1'b1;
      end else begin
        nxt_o.ring = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdm_dtr_stage.sv
// Register write: DTR edge handling plus load of control bits.
module mdm_dtr_stage
  import mdm_pkg::*;
(
  input  mdm_state_t cur_i,
  input  logic       wr_en_i,
  input  mdm_ctrl_t  ctrl_i,
  input  logic       line_up_i,
  output mdm_state_t nxt_o,
  output logic       hangup_o
);
  logic dtr_rise, dtr_fall;

  assign dtr_rise = wr_en_i &  ctrl_i.dtr & ~cur_i.dtr;
  assign dtr_fall = wr_en_i & ~ctrl_i.dtr &  cur_i.dtr;
  assign hangup_o = dtr_fall & line_up_i;

  always_comb begin
    nxt_o = cur_i;
    if (dtr_rise && line_up_i) begin
      nxt_o.ring = 1'b0;
      nxt_o.cd   = 1'b1;
      nxt_o.cts  = 1'b1;
      nxt_o.dsc  = 1'b1;
    end else if (dtr_rise || dtr_fall) begin
      if (line_up_i && cur_i.cd) nxt_o.dsc = 1'b1;
      nxt_o.cd   = 1'b0;
      nxt_o.ring = 1'b0;
      nxt_o.cts  = 1'b0;
    end
    if (wr_en_i) begin
      nxt_o.dsie = ctrl_i.dsie;
      nxt_o.secx = ctrl_i.secx;
      nxt_o.rts  = ctrl_i.rts;
      nxt_o.dtr  = ctrl_i.dtr;
    end
  end
endmodule

// File: rtl/mdm_status_fmt.sv
// Places state bits at their word positions; zero when modem mode is off.
module mdm_status_fmt
  import mdm_pkg::*;
(
  input  mdm_state_t       st_i,
  input  logic             en_i,
  output logic [REG_W-1:0] word_o
);
  localparam int NB = $bits(mdm_state_t);
  localparam int POS_TBL [NB] = '{POS_DSC, POS_RING, POS_CTS, POS_CD, POS_SRX,
                                  POS_DSIE, POS_SECX, POS_RTS, POS_DTR};
  logic [NB-1:0] flat;
  assign flat = st_i;

  always_comb begin
    word_o = '0;
    for (int i = 0; i < NB; i++) begin
      word_o[POS_TBL[i]] = en_i & flat[NB-1-i];
    end
  end
endmodule

// File: rtl/mdm_status_ctrl.sv
module mdm_status_ctrl
  import mdm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             modem_en_i,
  input  logic             line_rst_i,
  input  logic             line_up_i,
  input  logic             conn_pulse_i,
  input  logic             sec_rx_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [REG_W-1:0] status_o,
  output logic             ds_irq_o,
  output logic             hangup_o
);
  mdm_state_t state_q, state_d;
  mdm_state_t s_rd, s_link, s_wr;
  mdm_ctrl_t  ctrl;
  logic       hangup_q, hangup_c;
  logic       unused_wr_bits;

  assign ctrl = unpack_ctrl(wr_data_i);
  assign unused_wr_bits = ^{wr_data_i[REG_W-1:POS_DSIE+1], wr_data_i[POS_DSIE-1],
                            wr_data_i[0]};

  // Order inside a cycle: read clear, line events, write.
  always_comb begin
    s_rd = state_q;
    if (rd_en_i) s_rd.dsc = 1'b0;
  end

  mdm_link_stage u_link (
    .cur_i       (s_rd),
    .line_up_i   (line_up_i),
    .conn_pulse_i(conn_pulse_i),
    .nxt_o       (s_link)
  );

  mdm_dtr_stage u_dtr (
    .cur_i    (s_link),
    .wr_en_i  (wr_en_i),
    .ctrl_i   (ctrl),
    .line_up_i(line_up_i),
    .nxt_o    (s_wr),
    .hangup_o (hangup_c)
  );

  always_comb begin
    state_d = '0;
    if (modem_en_i) begin
      if (line_rst_i) begin
        state_d.dtr = state_q.dtr;
      end else begin
        state_d        = s_wr;
        state_d.sec_rx = sec_rx_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= '0;
      hangup_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      hangup_q <= modem_en_i & ~line_rst_i & hangup_c;
    end
  end

  mdm_status_fmt u_fmt (
    .st_i  (state_q),
    .en_i  (modem_en_i),
    .word_o(status_o)
  );

  assign ds_irq_o = modem_en_i & state_q.dsc & state_q.dsie;
  assign hangup_o = modem_en_i & hangup_q;

  assert_rd_clears_dsc_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (modem_en_i && rd_en_i && line_up_i && !conn_pulse_i && !wr_en_i && !line_rst_i)
    |=> !state_q.dsc);

  assert_drop_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (modem_en_i && !line_up_i) |=> !(state_q.cd || state_q.ring || state_q.cts));

  assert_hangup_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hangup_o |-> $past(wr_en_i && line_up_i && state_q.dtr && !wr_data_i[POS_DTR]));

  assert_enable_raises_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (modem_en_i && !line_rst_i && wr_en_i && wr_data_i[POS_DSIE] && state_q.dsc && !rd_en_i)
    |=> (ds_irq_o || !modem_en_i));

  assert_line_rst_keeps_dtr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (modem_en_i && line_rst_i)
    |=> (state_q.dtr == $past(state_q.dtr)) && ($countones(state_q) == 32'(state_q.dtr)));

  assert_mode_off_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !modem_en_i |=> (state_q == '0));
endmodule

// File: tb/mdm_status_ctrl_bench.sv
module mdm_status_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        modem_en = 1'b1, line_rst = 1'b0, line_up = 1'b0, conn = 1'b0;
  logic        sec_rx = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] status;
  logic        irq, hup;
  int          n_tests = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  mdm_status_ctrl u_mdm_status_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .modem_en_i(modem_en), .line_rst_i(line_rst),
    .line_up_i(line_up), .conn_pulse_i(conn), .sec_rx_i(sec_rx), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .status_o(status), .ds_irq_o(irq),
    .hangup_o(hup)
  );

  // {up, conn, wr, rd, wdata[16], exp_status[16], exp_irq, exp_hup, req[4]}
  localparam int NV = 23;
  localparam logic [41:0] VECS [NV] = '{
    {4'b0000, 16'h0000, 16'h0000, 2'b00, 4'd6 },  // idle, line down: R6
    {4'b0010, 16'h002C, 16'h002C, 2'b00, 4'd1 },  // control bits load: R1
    {4'b0010, 16'hF02C, 16'h002C, 2'b00, 4'd1 },  // read-only bits ignored: R1
    {4'b1100, 16'h0000, 16'hC02C, 2'b10, 4'd3 },  // connect, DTR clear: R3
    {4'b1001, 16'h0000, 16'h402C, 2'b00, 4'd7 },  // read clears change: R7
    {4'b1010, 16'h002E, 16'hB02E, 2'b10, 4'd4 },  // DTR rise connected: R4
    {4'b1001, 16'h0000, 16'h302E, 2'b00, 4'd7 },
    {4'b1010, 16'h000E, 16'h300E, 2'b00, 4'd1 },
    {4'b1010, 16'h000C, 16'h800C, 2'b01, 4'd5 },  // DTR fall with carrier: R5
    {4'b1010, 16'h002C, 16'h802C, 2'b10, 4'd8 },  // enable while set: R8
    {4'b1101, 16'h0000, 16'hC02C, 2'b10, 4'd7 },  // read + connect: R7
    {4'b1011, 16'h002E, 16'hB02E, 2'b10, 4'd4 },  // read + DTR rise: R4
    {4'b1001, 16'h0000, 16'h302E, 2'b00, 4'd7 },
    {4'b0000, 16'h0000, 16'h802E, 2'b10, 4'd6 },  // drop with carrier: R6
    {4'b0001, 16'h0000, 16'h002E, 2'b00, 4'd7 },
    {4'b0000, 16'h0000, 16'h002E, 2'b00, 4'd6 },  // down, no carrier: R6
    {4'b0100, 16'h0000, 16'h002E, 2'b00, 4'd13},  // connect while down: R13
    {4'b1100, 16'h0000, 16'hB02E, 2'b10, 4'd2 },  // connect, DTR set: R2
    {4'b1010, 16'h0000, 16'h8000, 2'b01, 4'd5 },  // DTR fall: R5
    {4'b1000, 16'h0000, 16'h8000, 2'b00, 4'd5 },  // pulse one cycle: R5
    {4'b1001, 16'h0000, 16'h0000, 2'b00, 4'd7 },
    {4'b0010, 16'h0002, 16'h0002, 2'b00, 4'd4 },  // rise while down: R4
    {4'b0010, 16'h0000, 16'h0000, 2'b00, 4'd5 }   // fall while down: R5
  };

  task automatic chk(input string req, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [15:0] st, input logic ei,
                         input logic eh);
    chk(req, "status", status, st);
    chk(req, "irq", {15'b0, irq}, {15'b0, ei});
    chk(req, "hangup", {15'b0, hup}, {15'b0, eh});
  endtask

  task automatic step(input logic up, input logic cp, input logic w, input logic r,
                      input logic [15:0] d);
    line_up = up; conn = cp; wr_en = w; rd_en = r; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    conn = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R11 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R11", 16'h0000, 1'b0, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk_all("R11", 16'h0000, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      v = VECS[i];
      step(v[41], v[40], v[39], v[38], v[37:22]);
      chk_all($sformatf("R%0d", v[3:0]), v[21:6], v[5], v[4]);
    end

    // R9: line reset keeps DTR only
    step(1'b1, 1'b0, 1'b1, 1'b0, 16'h002E);
    chk_all("R4", 16'hB02E, 1'b1, 1'b0);
    line_rst = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);
    line_rst = 1'b0;
    chk_all("R9", 16'h0002, 1'b0, 1'b0);

    // R12: secondary receive sampling
    sec_rx = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);
    chk_all("R12", 16'h0402, 1'b0, 1'b0);
    sec_rx = 1'b0;
    step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);
    chk_all("R12", 16'h0002, 1'b0, 1'b0);

    // R10: mode off
    step(1'b1, 1'b1, 1'b0, 1'b0, 16'h0000);
    chk_all("R2", 16'hB002, 1'b0, 1'b0);
    modem_en = 1'b0;
    #1;
    chk_all("R10", 16'h0000, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b0, 16'h002C);
    chk_all("R10", 16'h0000, 1'b0, 1'b0);
    modem_en = 1'b1;
    #1;
    chk_all("R10", 16'h0000, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);
    chk_all("R10", 16'h0000, 1'b0, 1'b0);

    // R11: asynchronous reset mid-run
    step(1'b1, 1'b0, 1'b1, 1'b0, 16'h002E);
    chk_all("R4", 16'hB02E, 1'b1, 1'b0);
    rst_ni = 1'b0;
    #1;
    chk_all("R11", 16'h0000, 1'b0, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;
    step(1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);
    chk_all("R11", 16'h0000, 1'b0, 1'b0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule